// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small 8-bit accumulator processor. It holds the eight-bit status register. A combinational datapath takes an operation code, the accumulator operand and a second operand (a memory byte or an index value), and produces an 8-bit result together with the next value of the status register. On every clock the status register loads that next value. Instruction decode and memory access are done elsewhere. The surrounding core steers operands in and writes the result wherever the instruction needs it.

Each operation writes only its own subset of the flags, and every other flag keeps its value. Addition and subtraction chain through the carry flag, so multi-byte sums and differences can be built one byte at a time. Software can set and clear the decimal flag, but the arithmetic never reads it: all arithmetic is plain binary. Status bit order, from bit 7 down to bit 0: N (negative), V (overflow), a reserved bit that always reads 1, B (break, never written here), D (decimal), I (interrupt disable), Z (zero), C (carry).

Top module: `accflag_alu`

## Requirements
- R1: After a synchronous reset the status register reads 0x24 (reserved bit 5 and I bit 2 set, all others clear). Out of reset it loads `flags_next_o` on every rising clock edge. B (bit 4) is never changed by any operation.
- R2: Op 1 (add with carry) gives result = (A + M + C) mod 256. C becomes the carry out, V is set on signed overflow, N is result bit 7, and Z is set when the result is zero.
- R3: Op 2 (subtract with carry) gives result = (A + ~M + C) mod 256. C becomes 1 exactly when A - M - (1 - C) does not go below zero. V is set on signed overflow, and N and Z follow the result.
- R4: Ops 3, 4 and 5 give A AND M, A OR M and A XOR M. They update N and Z from the result and leave C and V unchanged.
- R5: Op 6 shifts A left with a 0 entering bit 0. Op 7 shifts A right with a 0 entering bit 7. The bit shifted out goes to C, and N and Z follow the result.
- R6: Op 8 rotates A left with the old C entering bit 0. Op 9 rotates A right with the old C entering bit 7. The bit shifted out goes to C, and N and Z follow the result.
- R7: Op 10 gives (M + 1) mod 256 and op 11 gives (M - 1) mod 256. Both update only N and Z.
- R8: Op 12 (compare) outputs A unchanged. It sets C when A >= M unsigned, sets N and Z from (A - M) mod 256, and leaves V unchanged.
- R9: Op 13 (bit test) outputs A unchanged. It sets Z when (A AND M) is zero, copies M bit 7 into N and M bit 6 into V, and leaves C unchanged.
- R10: Ops 14..20 are clear C, set C, clear D, set D, clear I, set I and clear V. Each changes only its own flag and outputs A.
- R11: The D flag has no effect on the results or flags of ops 1 and 2.
- R12: Op 0 and ops 21..31 output A and leave the status register unchanged. Bit 5 of the status register reads 1 at all times out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Memory or index operand |
| result_o | output | 8 | Combinational result |
| flags_next_o | output | 8 | Status value loaded at the next edge |
| flags_o | output | 8 | Registered status |

## Verification
A flag write from the current operation and the retention of the flags it does not own happen in the same cycle. A wrong write mask can hide behind the right-looking flag, so the bench compares all eight status bits on every cycle. The carry written by one operation and its use as an input by the next are a second such pair. Back-to-back chained add, subtract and rotate sequences provoke this, and a cycle-exact reference model judges every bit of the result and status. Directed steps pin down the boundaries: 0x7F+1 and 0xFF+1, borrow from zero, equal and unequal compares, and decimal-flag-set arithmetic.

// File: rtl/accflag_alu_pkg.sv
package accflag_alu_pkg;

    localparam int FLAG_W = 8;
    localparam logic [FLAG_W-1:0] FLAGS_RST = 8'h24;

    typedef enum logic [4:0] {
        OP_NOP = 5'd0,
        OP_ADC = 5'd1,
        OP_SBC = 5'd2,
        OP_AND = 5'd3,
        OP_ORA = 5'd4,
        OP_EOR = 5'd5,
        OP_ASL = 5'd6,
        OP_LSR = 5'd7,
        OP_ROL = 5'd8,
        OP_ROR = 5'd9,
        OP_INC = 5'd10,
        OP_DEC = 5'd11,
        OP_CMP = 5'd12,
        OP_BIT = 5'd13,
        OP_CLC = 5'd14,
        OP_SEC = 5'd15,
        OP_CLD = 5'd16,
        OP_SED = 5'd17,
        OP_CLI = 5'd18,
        OP_SEI = 5'd19,
        OP_CLV = 5'd20
    } alu_op_e;

    // status layout, bit 7 first
    typedef struct packed {
        logic n;
        logic v;
        logic r;
        logic b;
        logic d;
        logic i;
        logic z;
        logic c;
    } flags_t;

    // write mask and values produced by one execution unit
    typedef struct packed {
        logic wr_n;
        logic wr_z;
        logic wr_c;
        logic wr_v;
        logic n;
        logic z;
        logic c;
        logic v;
    } flag_upd_t;

    function automatic logic is_logic_op(alu_op_e op);
        return (op == OP_AND) || (op == OP_ORA) || (op == OP_EOR);
    endfunction

endpackage

// File: rtl/accflag_alu_arith.sv
module accflag_alu_arith
    import accflag_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] m,
    input  logic         cin,
    output logic [W-1:0] res,
    output flag_upd_t    upd,
    output logic         sel
);

    localparam int SW = W + 1;

    logic [W-1:0]  opa;
    logic [W-1:0]  opb;
    logic          ci;
    logic [SW-1:0] sum;

    always_comb begin
        opa = a;
        opb = m;
        ci  = cin;
        sel = 1'b1;
        upd = '0;
        unique case (op)
            OP_ADC: begin
                upd.wr_n = 1'b1; upd.wr_z = 1'b1; upd.wr_c = 1'b1; upd.wr_v = 1'b1;
            end
            OP_SBC: begin
                opb = ~m;
                upd.wr_n = 1'b1; upd.wr_z = 1'b1; upd.wr_c = 1'b1; upd.wr_v = 1'b1;
            end
            OP_CMP: begin
                opb = ~m;
                ci  = 1'b1;
                upd.wr_n = 1'b1; upd.wr_z = 1'b1; upd.wr_c = 1'b1;
            end
            OP_INC: begin
                opa = m;
                opb = '0;
                ci  = 1'b1;
                upd.wr_n = 1'b1; upd.wr_z = 1'b1;
            end
            OP_DEC: begin
                opa = m;
                opb = '1;
                ci  = 1'b0;
                upd.wr_n = 1'b1; upd.wr_z = 1'b1;
            end
            default: sel = 1'b0;
        endcase
        sum   = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, ci};
        upd.n = sum[W-1];
        upd.z = (sum[W-1:0] == '0);
        upd.c = sum[W];
        upd.v = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
        res   = (op == OP_CMP) ? a : sum[W-1:0];
    end

    // R8
    cmp_ge_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CMP) |-> (upd.c == (a >= m)) && !upd.wr_v && (res == a));

    // R3
    sbc_noborrow_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SBC && cin) |-> (upd.c == (a >= m)));

    // R7
    incdec_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INC || op == OP_DEC) |-> (!upd.wr_c && !upd.wr_v));

endmodule

// File: rtl/accflag_alu_logic.sv
module accflag_alu_logic
    import accflag_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] m,
    input  logic         cin,
    output logic [W-1:0] res,
    output flag_upd_t    upd,
    output logic         sel
);

    logic [W-1:0] masked;

    always_comb begin
        masked = a & m;
        res    = a;
        sel    = 1'b1;
        upd    = '0;
        unique case (op)
            OP_AND: res = masked;
            OP_ORA: res = a | m;
            OP_EOR: res = a ^ m;
            OP_ASL: begin
                res = {a[W-2:0], 1'b0};
                upd.wr_c = 1'b1; upd.c = a[W-1];
            end
            OP_LSR: begin
                res = {1'b0, a[W-1:1]};
                upd.wr_c = 1'b1; upd.c = a[0];
            end
            OP_ROL: begin
                res = {a[W-2:0], cin};
                upd.wr_c = 1'b1; upd.c = a[W-1];
            end
            OP_ROR: begin
                res = {cin, a[W-1:1]};
                upd.wr_c = 1'b1; upd.c = a[0];
            end
            OP_BIT: res = a;
            default: sel = 1'b0;
        endcase
        upd.wr_n = sel;
        upd.wr_z = sel;
        if (op == OP_BIT) begin
            upd.n    = m[W-1];
            upd.v    = m[W-2];
            upd.z    = (masked == '0);
            upd.wr_v = 1'b1;
        end else begin
            upd.n = res[W-1];
            upd.z = (res == '0);
        end
    end

    // R6
    rol_in_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ROL) |-> (res[0] == cin) && (upd.c == a[W-1]));

    // R6
    ror_in_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ROR) |-> (res[W-1] == cin) && (upd.c == a[0]));

    // R9
    bit_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BIT) |-> (upd.n == m[W-1]) && (upd.v == m[W-2]) && !upd.wr_c);

endmodule

// File: rtl/accflag_alu_flagmux.sv
module accflag_alu_flagmux
    import accflag_alu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  alu_op_e   op,
    input  flags_t    cur,
    input  flag_upd_t arith_upd,
    input  logic      arith_sel,
    input  flag_upd_t logic_upd,
    input  logic      logic_sel,
    output flags_t    nxt
);

    flag_upd_t u;

    always_comb begin
        u = arith_sel ? arith_upd : (logic_sel ? logic_upd : '0);
        nxt   = cur;
        nxt.r = 1'b1;
        if (u.wr_n) nxt.n = u.n;
        if (u.wr_z) nxt.z = u.z;
        if (u.wr_c) nxt.c = u.c;
        if (u.wr_v) nxt.v = u.v;
        unique case (op)
            OP_CLC:  nxt.c = 1'b0;
            OP_SEC:  nxt.c = 1'b1;
            OP_CLD:  nxt.d = 1'b0;
            OP_SED:  nxt.d = 1'b1;
            OP_CLI:  nxt.i = 1'b0;
            OP_SEI:  nxt.i = 1'b1;
            OP_CLV:  nxt.v = 1'b0;
            default: ;
        endcase
    end

    // R12
    unit_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({arith_sel, logic_sel}));

    // R4
    logic_keep_chk: assert property (@(posedge clk) disable iff (rst)
        is_logic_op(op) |-> (nxt.c == cur.c) && (nxt.v == cur.v));

    // R10
    clv_only_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLV) |-> !nxt.v && (nxt.c == cur.c) && (nxt.z == cur.z)
                           && (nxt.n == cur.n) && (nxt.d == cur.d) && (nxt.i == cur.i));

    // R1
    brk_keep_chk: assert property (@(posedge clk) disable iff (rst)
        nxt.b == cur.b);

endmodule

// File: rtl/accflag_alu.sv
module accflag_alu
    import accflag_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        op_i,
    input  logic [W-1:0]      acc_i,
    input  logic [W-1:0]      opnd_i,
    output logic [W-1:0]      result_o,
    output logic [FLAG_W-1:0] flags_next_o,
    output logic [FLAG_W-1:0] flags_o
);

    alu_op_e      op;
    flags_t       flags_q;
    flags_t       flags_d;
    logic [W-1:0] ar_res;
    logic [W-1:0] lg_res;
    flag_upd_t    ar_upd;
    flag_upd_t    lg_upd;
    logic         ar_sel;
    logic         lg_sel;

    assign op = alu_op_e'(op_i);

    accflag_alu_arith #(.W(W)) u_arith (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .a   (acc_i),
        .m   (opnd_i),
        .cin (flags_q.c),
        .res (ar_res),
        .upd (ar_upd),
        .sel (ar_sel)
    );

    accflag_alu_logic #(.W(W)) u_logic (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .a   (acc_i),
        .m   (opnd_i),
        .cin (flags_q.c),
        .res (lg_res),
        .upd (lg_upd),
        .sel (lg_sel)
    );

    accflag_alu_flagmux u_flagmux (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .cur       (flags_q),
        .arith_upd (ar_upd),
        .arith_sel (ar_sel),
        .logic_upd (lg_upd),
        .logic_sel (lg_sel),
        .nxt       (flags_d)
    );

    always_comb begin
        if (ar_sel)      result_o = ar_res;
        else if (lg_sel) result_o = lg_res;
        else             result_o = acc_i;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= flags_t'(FLAGS_RST);
        else     flags_q <= flags_d;
    end

    assign flags_next_o = flags_d;
    assign flags_o      = flags_q;

    // R1
    status_load_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (flags_o == $past(flags_next_o)));

    // R12
    reserved_one_chk: assert property (@(posedge clk) disable iff (rst)
        flags_o[5] == 1'b1);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 5'd0 || op_i > 5'd20) |-> (flags_next_o == flags_o) && (result_o == acc_i));

endmodule

// File: tb/accflag_alu_bench.sv
`timescale 1ns/1ps
module accflag_alu_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic [7:0] result_o;
    logic [7:0] flags_next_o;
    logic [7:0] flags_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] mflags = 8'h24;

    always #2 clk = ~clk;

    accflag_alu u_accflag_alu (
        .clk          (clk),
        .rst          (rst),
        .op_i         (op_i),
        .acc_i        (acc_i),
        .opnd_i       (opnd_i),
        .result_o     (result_o),
        .flags_next_o (flags_next_o),
        .flags_o      (flags_o)
    );

    function automatic string tag_of(int op);
        case (op)
            1:       return "R2";
            2:       return "R3";
            3, 4, 5: return "R4";
            6, 7:    return "R5";
            8, 9:    return "R6";
            10, 11:  return "R7";
            12:      return "R8";
            13:      return "R9";
            14, 15, 16, 17, 18, 19, 20: return "R10";
            default: return "R12";
        endcase
    endfunction

    function automatic int sgn(int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    // returns {result, next flags}
    function automatic logic [15:0] model(int op, int a, int m, logic [7:0] f);
        int r = a;
        int c = f[0] ? 1 : 0;
        int s;
        logic [7:0] nf = f;
        logic setnz = 1'b0;
        case (op)
            1: begin
                s = a + m + c; r = s % 256; nf[0] = (s > 255);
                s = sgn(a) + sgn(m) + c; nf[6] = (s > 127) || (s < -128); setnz = 1;
            end
            2: begin
                s = a - m - (1 - c); r = (s + 256) % 256; nf[0] = (s >= 0);
                s = sgn(a) - sgn(m) - (1 - c); nf[6] = (s > 127) || (s < -128); setnz = 1;
            end
            3: begin r = a & m; setnz = 1; end
            4: begin r = a | m; setnz = 1; end
            5: begin r = a ^ m; setnz = 1; end
            6: begin r = (a * 2) % 256; nf[0] = (a >= 128); setnz = 1; end
            7: begin r = a / 2; nf[0] = (a % 2 == 1); setnz = 1; end
            8: begin r = (a * 2) % 256 + c; nf[0] = (a >= 128); setnz = 1; end
            9: begin r = a / 2 + c * 128; nf[0] = (a % 2 == 1); setnz = 1; end
            10: begin r = (m + 1) % 256; setnz = 1; end
            11: begin r = (m + 255) % 256; setnz = 1; end
            12: begin
                s = (a - m + 256) % 256;
                nf[0] = (a >= m); nf[7] = (s >= 128); nf[1] = (s == 0);
            end
            13: begin
                nf[1] = ((a & m) == 0); nf[7] = (m >= 128); nf[6] = ((m / 64) % 2 == 1);
            end
            14: nf[0] = 0;
            15: nf[0] = 1;
            16: nf[3] = 0;
            17: nf[3] = 1;
            18: nf[2] = 0;
            19: nf[2] = 1;
            20: nf[6] = 0;
            default: ;
        endcase
        if (setnz) begin
            nf[7] = (r >= 128);
            nf[1] = (r == 0);
        end
        nf[5] = 1'b1;
        return {r[7:0], nf};
    endfunction

    task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // drive one operation, check it, advance one clock
    task automatic step(int op, int a, int m);
        logic [15:0] e;
        op_i   = op[4:0];
        acc_i  = a[7:0];
        opnd_i = m[7:0];
        #1;
        e = model(op, a, m, mflags);
        check8("R1", "flags_o", flags_o, mflags);
        check8(tag_of(op), "result", result_o, e[15:8]);
        check8(tag_of(op), "flags_next", flags_next_o, e[7:0]);
        mflags = e[7:0];
        @(negedge clk);
    endtask

    // decimal mode must not change binary arithmetic
    task automatic dec_check(int op, int a, int m);
        logic [15:0] e;
        op_i = op[4:0]; acc_i = a[7:0]; opnd_i = m[7:0];
        #1;
        e = model(op, a, m, mflags);
        check8("R11", "result with D set", result_o, e[15:8]);
        check8("R11", "flags with D set", flags_next_o, e[7:0]);
        mflags = e[7:0];
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check8("R1", "reset status", flags_o, 8'h24);
        rst = 1'b0;
        mflags = 8'h24;
        // R2 signed overflow and carry out
        step(15, 0, 0);  step(1, 8'h7F, 8'h00);
        step(14, 0, 0);  step(1, 8'hFF, 8'h01);
        step(1, 8'h80, 8'h80); step(1, 8'h10, 8'h20);
        // R3 overflow and borrow
        step(15, 0, 0);  step(2, 8'h50, 8'hB0);
        step(15, 0, 0);  step(2, 8'h00, 8'h01);
        step(2, 8'h05, 8'h03);
        // R11 D set, binary result expected
        step(17, 0, 0);
        dec_check(1, 8'h09, 8'h01);
        dec_check(2, 8'h10, 8'h01);
        step(16, 0, 0);
        // R8 compare equal, less, greater
        step(12, 8'h40, 8'h40); step(12, 8'h10, 8'h40); step(12, 8'h90, 8'h10);
        // R9 bit test
        step(9'd13, 8'h3F, 8'hC0); step(13, 8'h01, 8'h41);
        // R6 rotates through carry, R5 shifts
        step(15, 0, 0); step(8, 8'h80, 0); step(8, 8'h01, 0); step(9, 8'h01, 0); step(9, 8'h00, 0);
        step(6, 8'h81, 0); step(7, 8'h01, 0);
        // R7 wrap
        step(10, 0, 8'hFF); step(11, 0, 8'h00); step(10, 0, 8'h7F);
        // R4 logic
        step(3, 8'hF0, 8'h0F); step(4, 8'h80, 8'h01); step(5, 8'hAA, 8'hAA);
        // R10 flag ops
        step(19, 0, 0); step(18, 0, 0); step(20, 0, 0); step(15, 0, 0); step(14, 0, 0);
        // R12 idle codes
        step(0, 8'h5A, 8'h11); step(25, 8'hA5, 8'h22); step(31, 8'h00, 8'h33);
        // mixed random traffic, chained carries
        for (int k = 0; k < 3000; k++) begin
            step(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 255)));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule